// File: doc/BRIEF.md
# Circular Transfer Record History Buffer

This block keeps a history of control-transfer records (branches, jumps, calls, returns, traps) in a power-of-two ring of entries. Each entry holds three words: a source address, a target address and a data word with the record's kind. Physically, records are written at a write pointer that moves around the ring. Software sees a shifting list instead: logical entry 0 is always the newest record, entry 1 the one before it, and so on. A read port takes a selector value, subtracts a fixed base to get the logical entry, and returns that entry's three words.

The active depth can be set at run time with a small depth-select field. A stack mode flag on the write command makes the ring act as a return-address stack. In that mode a return record pops the newest entry instead of adding one. A coroutine-swap record replaces the newest entry in place. Filtering decides which transfers reach the buffer, and that filtering lives upstream. This block only stores what it is told to store.

Top module: `trhist_buf`

## Requirements
- R1: The active depth is 16 << depth_sel, with depth_sel clamped to MAX_SEL (default 4, so 256 entries at most). All pointer and index arithmetic wraps modulo the active depth.
- R2: A write that is neither a stack-mode return nor a stack-mode swap stores the record at the slot the pointer names, then advances wrptr by one. Without a write, wrptr holds.
- R3: A stored entry reads back as follows. The source word is the source address with bit 0 (valid) set. The target word is the target address with bit 0 (mispredict) cleared. The data word holds only the 4-bit kind in bits [3:0], with all higher bits zero.
- R4: For selector s, the logical entry is e = s - 0x200. Entry e reads physical slot (wrptr - e - 1) mod depth, so entry 0 is the newest record.
- R5: With wr_stack = 1 and kind 13 (return), wrptr steps back by one and the valid bit of the slot it then names is cleared. No entry is written.
- R6: With wr_stack = 1 and kind 12 (coroutine swap), the newest entry (slot wrptr - 1) is overwritten and wrptr ends unchanged.
- R7: The read port is combinational from stored state. A read in the same cycle as a write returns the contents from before the write.
- R8: Reset clears wrptr and every valid bit.
- R9: A selector below 0x200, or one whose logical entry is at or beyond the active depth, reads all three words as zero.
- R10: Kinds 12 and 13 with wr_stack = 0, and every other kind with wr_stack = 1, are written as ordinary records per R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| depth_sel | input | DSEL_W | Depth select; the depth is 16 << min(depth_sel, MAX_SEL) |
| wr_en | input | 1 | Write command strobe |
| wr_kind | input | 4 | Record kind; 12 is coroutine swap, 13 is return |
| wr_src | input | ADDR_W | Source address of the transfer |
| wr_tgt | input | ADDR_W | Target address of the transfer |
| wr_stack | input | 1 | Return-stack emulation mode |
| rd_sel | input | 12 | Entry selector; logical entry = rd_sel - 0x200 |
| rd_src | output | ADDR_W | Source word of the selected entry, with valid in bit 0 |
| rd_tgt | output | ADDR_W | Target word of the selected entry, with mispredict in bit 0 |
| rd_data | output | ADDR_W | Data word of the selected entry, with kind in bits [3:0] |
| wrptr | output | 4+MAX_SEL | Physical write pointer status |

## Verification
The hardest states to reach are two. The first is a stack-mode pop followed by a swap, so that a cleared slot sits just past the pointer while the new newest entry is a rewritten older one. The second is a pointer that has wrapped at the largest clamped depth while the selector reaches the last legal entry and the first entry past it. The vector table mixes stack-mode returns and swaps with the same kinds written outside stack mode. It reads the newest, next and oldest logical entries after every step. A directed run then raises depth_sel past the clamp, pushes a full 256-entry lap and probes both edges of the read window.

// File: rtl/trhist_pkg.sv
package trhist_pkg;

    localparam int BASE_LOG2 = 4;
    localparam int KIND_W    = 4;
    localparam int SEL_W     = 12;
    localparam logic [SEL_W-1:0] SEL_BASE = 12'h200;

    typedef enum logic [KIND_W-1:0] {
        K_NONE    = 4'd0,
        K_EXC     = 4'd1,
        K_INT     = 4'd2,
        K_TRET    = 4'd3,
        K_BR_NT   = 4'd4,
        K_BR_T    = 4'd5,
        K_ICALL   = 4'd8,
        K_DCALL   = 4'd9,
        K_IJMP    = 4'd10,
        K_DJMP    = 4'd11,
        K_CORSWAP = 4'd12,
        K_RETURN  = 4'd13,
        K_OIJMP   = 4'd14,
        K_ODJMP   = 4'd15
    } xfer_kind_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_SWAP
    } wr_op_e;

    function automatic wr_op_e classify_op(input logic en, input logic stack,
                                           input logic [KIND_W-1:0] kind);
        if (!en)
            return OP_IDLE;
        else if (stack && kind == K_RETURN)
            return OP_POP;
        else if (stack && kind == K_CORSWAP)
            return OP_SWAP;
        else
            return OP_PUSH;
    endfunction

endpackage

// File: rtl/trhist_ptr.sv
module trhist_ptr
    import trhist_pkg::*;
#(
    parameter int MAX_SEL = 4,
    parameter int DSEL_W  = 3,
    localparam int PTR_W  = BASE_LOG2 + MAX_SEL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DSEL_W-1:0] depth_sel,
    input  wr_op_e            op,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [PTR_W-1:0]  mask_o,
    output logic              we_o,
    output logic [PTR_W-1:0]  wslot_o,
    output logic              clr_o,
    output logic [PTR_W-1:0]  cslot_o
);

    logic [PTR_W-1:0]  ptr_q, ptr_d, ptr_inc, ptr_dec, mask;
    logic [DSEL_W-1:0] act_sel;

    always_comb begin
        act_sel = (depth_sel > DSEL_W'(MAX_SEL)) ? DSEL_W'(MAX_SEL) : depth_sel;
        for (int i = 0; i < PTR_W; i++)
            mask[i] = (i < BASE_LOG2 + int'(act_sel));
    end

    assign ptr_inc = (ptr_q + PTR_W'(1)) & mask;
    assign ptr_dec = (ptr_q - PTR_W'(1)) & mask;

    always_comb begin
        ptr_d   = ptr_q;
        we_o    = 1'b0;
        wslot_o = ptr_q & mask;
        clr_o   = 1'b0;
        cslot_o = ptr_dec;
        unique case (op)
            OP_PUSH: begin
                we_o  = 1'b1;
                ptr_d = ptr_inc;
            end
            OP_SWAP: begin
                we_o    = 1'b1;
                wslot_o = ptr_dec;
                ptr_d   = ptr_q & mask;
            end
            OP_POP: begin
                clr_o = 1'b1;
                ptr_d = ptr_dec;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else
            ptr_q <= ptr_d;
    end

    assign ptr_o  = ptr_q;
    assign mask_o = mask;

endmodule

// File: rtl/trhist_store.sv
module trhist_store
    import trhist_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SLOT_W = 8,
    localparam int DEPTH = 1 << SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [ADDR_W-2:0] wsrc_hi,
    input  logic [ADDR_W-2:0] wtgt_hi,
    input  logic [KIND_W-1:0] wkind,
    input  logic              clr,
    input  logic [SLOT_W-1:0] cslot,
    input  logic [SLOT_W-1:0] rslot,
    output logic [ADDR_W-2:0] rsrc_hi,
    output logic [ADDR_W-2:0] rtgt_hi,
    output logic [KIND_W-1:0] rkind,
    output logic              rvalid
);

    logic [ADDR_W-2:0] src_mem  [DEPTH];
    logic [ADDR_W-2:0] tgt_mem  [DEPTH];
    logic [KIND_W-1:0] kind_mem [DEPTH];
    logic              vld_q    [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            src_mem[wslot]  <= wsrc_hi;
            tgt_mem[wslot]  <= wtgt_hi;
            kind_mem[wslot] <= wkind;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
        always_ff @(posedge clk) begin
            if (rst)
                vld_q[g] <= 1'b0;
            else if (we && wslot == SLOT_W'(g))
                vld_q[g] <= 1'b1;
            else if (clr && cslot == SLOT_W'(g))
                vld_q[g] <= 1'b0;
        end
    end

    assign rsrc_hi = src_mem[rslot];
    assign rtgt_hi = tgt_mem[rslot];
    assign rkind   = kind_mem[rslot];
    assign rvalid  = vld_q[rslot];

endmodule

// File: rtl/trhist_rdmap.sv
module trhist_rdmap
    import trhist_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic [SEL_W-1:0] rd_sel,
    input  logic [PTR_W-1:0] ptr,
    input  logic [PTR_W-1:0] mask,
    output logic [PTR_W-1:0] slot,
    output logic             in_win
);

    logic [SEL_W-1:0] ofs, mask_w;

    assign ofs    = rd_sel - SEL_BASE;
    assign mask_w = {{(SEL_W-PTR_W){1'b0}}, mask};
    assign in_win = (rd_sel >= SEL_BASE) && ((ofs & ~mask_w) == '0);
    assign slot   = (ptr - ofs[PTR_W-1:0] - PTR_W'(1)) & mask;

endmodule

// File: rtl/trhist_buf.sv
module trhist_buf
    import trhist_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int MAX_SEL = 4,
    parameter int DSEL_W  = 3,
    localparam int PTR_W  = BASE_LOG2 + MAX_SEL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DSEL_W-1:0] depth_sel,
    input  logic              wr_en,
    input  logic [KIND_W-1:0] wr_kind,
    input  logic [ADDR_W-1:0] wr_src,
    input  logic [ADDR_W-1:0] wr_tgt,
    input  logic              wr_stack,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [ADDR_W-1:0] rd_src,
    output logic [ADDR_W-1:0] rd_tgt,
    output logic [ADDR_W-1:0] rd_data,
    output logic [PTR_W-1:0]  wrptr
);

    wr_op_e            op;
    logic [PTR_W-1:0]  ptr, mask, wslot, cslot, rslot;
    logic              we, clr, in_win, rvalid;
    logic [ADDR_W-2:0] rsrc_hi, rtgt_hi;
    logic [KIND_W-1:0] rkind;

    assign op = classify_op(wr_en, wr_stack, wr_kind);

    trhist_ptr #(.MAX_SEL(MAX_SEL), .DSEL_W(DSEL_W)) u_ptr (
        .clk(clk), .rst(rst), .depth_sel(depth_sel), .op(op),
        .ptr_o(ptr), .mask_o(mask), .we_o(we), .wslot_o(wslot),
        .clr_o(clr), .cslot_o(cslot)
    );

    trhist_store #(.ADDR_W(ADDR_W), .SLOT_W(PTR_W)) u_store (
        .clk(clk), .rst(rst), .we(we), .wslot(wslot),
        .wsrc_hi(wr_src[ADDR_W-1:1]), .wtgt_hi(wr_tgt[ADDR_W-1:1]),
        .wkind(wr_kind), .clr(clr), .cslot(cslot), .rslot(rslot),
        .rsrc_hi(rsrc_hi), .rtgt_hi(rtgt_hi), .rkind(rkind), .rvalid(rvalid)
    );

    trhist_rdmap #(.PTR_W(PTR_W)) u_map (
        .rd_sel(rd_sel), .ptr(ptr), .mask(mask), .slot(rslot), .in_win(in_win)
    );

    assign rd_src  = in_win ? {rsrc_hi, rvalid} : '0;
    assign rd_tgt  = in_win ? {rtgt_hi, 1'b0}   : '0;
    assign rd_data = in_win ? {{(ADDR_W-KIND_W){1'b0}}, rkind} : '0;
    assign wrptr   = ptr;

endmodule

// File: rtl/trhist_chk.sv
module trhist_chk
    import trhist_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int MAX_SEL = 4,
    parameter int DSEL_W  = 3,
    localparam int PTR_W  = BASE_LOG2 + MAX_SEL
) (
    input logic              clk,
    input logic              rst,
    input logic [DSEL_W-1:0] depth_sel,
    input logic              wr_en,
    input logic [KIND_W-1:0] wr_kind,
    input logic              wr_stack,
    input logic [SEL_W-1:0]  rd_sel,
    input logic [ADDR_W-1:0] rd_src,
    input logic [ADDR_W-1:0] rd_tgt,
    input logic [ADDR_W-1:0] rd_data,
    input logic [PTR_W-1:0]  wrptr
);

    logic [PTR_W-1:0] msk;
    logic             is_pop, is_swap, is_push;

    always_comb begin
        for (int i = 0; i < PTR_W; i++)
            msk[i] = (i < BASE_LOG2 + ((int'(depth_sel) > MAX_SEL) ? MAX_SEL : int'(depth_sel)));
    end

    assign is_pop  = wr_en && wr_stack && wr_kind == 4'd13;
    assign is_swap = wr_en && wr_stack && wr_kind == 4'd12;
    assign is_push = wr_en && !is_pop && !is_swap;

    p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
        is_push |=> wrptr == (($past(wrptr) + PTR_W'(1)) & $past(msk)));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(wrptr));

    p_pop_step_r5: assert property (@(posedge clk) disable iff (rst)
        is_pop |=> wrptr == (($past(wrptr) - PTR_W'(1)) & $past(msk)));

    p_swap_keep_r6: assert property (@(posedge clk) disable iff (rst)
        is_swap |=> wrptr == ($past(wrptr) & $past(msk)));

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> wrptr == '0);

    p_tgt_flag_r3: assert property (@(posedge clk) disable iff (rst)
        rd_tgt[0] == 1'b0 && rd_data[ADDR_W-1:KIND_W] == '0);

    p_outwin_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_sel < SEL_BASE) |-> (rd_src == '0 && rd_tgt == '0 && rd_data == '0));

endmodule

bind trhist_buf trhist_chk #(.ADDR_W(ADDR_W), .MAX_SEL(MAX_SEL), .DSEL_W(DSEL_W)) u_chk (
    .clk(clk), .rst(rst), .depth_sel(depth_sel), .wr_en(wr_en),
    .wr_kind(wr_kind), .wr_stack(wr_stack), .rd_sel(rd_sel),
    .rd_src(rd_src), .rd_tgt(rd_tgt), .rd_data(rd_data), .wrptr(wrptr)
);

// File: tb/tb_trhist_buf.sv
module tb_trhist_buf;

    localparam int AW = 64;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    depth_sel = 3'd0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_kind = 4'd0;
    logic [AW-1:0] wr_src = '0;
    logic [AW-1:0] wr_tgt = '0;
    logic          wr_stack = 1'b0;
    logic [11:0]   rd_sel = 12'h200;
    logic [AW-1:0] rd_src, rd_tgt, rd_data;
    logic [PW-1:0] wrptr;

    trhist_buf dut (
        .clk(clk), .rst(rst), .depth_sel(depth_sel), .wr_en(wr_en),
        .wr_kind(wr_kind), .wr_src(wr_src), .wr_tgt(wr_tgt), .wr_stack(wr_stack),
        .rd_sel(rd_sel), .rd_src(rd_src), .rd_tgt(rd_tgt), .rd_data(rd_data),
        .wrptr(wrptr)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    logic [AW-1:0] msrc [256];
    logic [AW-1:0] mtgt [256];
    logic [3:0]    mkind[256];
    bit            mval [256];
    bit            mwr  [256];
    int            mptr = 0;
    int            bd   = 16;

    // {kind, stack, expected wrptr}
    localparam logic [12:0] VEC [8] = '{
        {4'd9,  1'b0, 8'd1},
        {4'd5,  1'b0, 8'd2},
        {4'd8,  1'b1, 8'd3},
        {4'd13, 1'b1, 8'd2},
        {4'd12, 1'b1, 8'd2},
        {4'd13, 1'b0, 8'd3},
        {4'd12, 1'b0, 8'd4},
        {4'd10, 1'b1, 8'd5}
    };

    task automatic chk(string req, logic [191:0] act, logic [191:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic model_write(logic [3:0] k, logic st, logic [AW-1:0] s, logic [AW-1:0] t);
        int m = bd - 1;
        int slot;
        if (st && k == 4'd13) begin
            mptr = (mptr - 1) & m;
            mval[mptr] = 1'b0;
        end else begin
            slot = (st && k == 4'd12) ? ((mptr - 1) & m) : mptr;
            msrc[slot] = s; mtgt[slot] = t; mkind[slot] = k;
            mval[slot] = 1'b1; mwr[slot] = 1'b1;
            if (!(st && k == 4'd12)) mptr = (mptr + 1) & m;
        end
    endtask

    task automatic do_write(logic [3:0] k, logic st, logic [AW-1:0] s, logic [AW-1:0] t);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_stack = st; wr_src = s; wr_tgt = t;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(k, st, s, t);
    endtask

    task automatic check_sel(logic [11:0] sel, string req);
        int e, slot;
        rd_sel = sel;
        #1;
        e = int'(sel) - 512;
        if (sel < 12'h200 || e >= bd) begin
            chk(req, {rd_src, rd_tgt, rd_data}, 192'd0);
        end else begin
            slot = (mptr - e - 1) & (bd - 1);
            if (mwr[slot])
                chk(req, {rd_src, rd_tgt, rd_data},
                    {msrc[slot][AW-1:1], mval[slot], mtgt[slot][AW-1:1], 1'b0, 60'd0, mkind[slot]});
            else
                chk(req, {191'd0, rd_src[0]}, {191'd0, mval[slot]});
        end
    endtask

    task automatic check_ptr(string req);
        #1;
        chk(req, {184'd0, wrptr}, {184'd0, 8'(mptr)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin mval[i] = 0; mwr[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        check_ptr("R8 ptr after reset");
        check_sel(12'h200, "R8 valid clear after reset");

        // Vector walk: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < 8; i++) begin
            logic [3:0] k;
            logic st;
            k  = VEC[i][12:9];
            st = VEC[i][8];
            do_write(k, st, 64'h1000 + 64'(i) * 16, 64'h8001 + 64'(i) * 32);
            #1;
            chk((st && k == 4'd13) ? "R5 pop ptr" : (st && k == 4'd12) ? "R6 swap ptr" : "R2 R10 push ptr",
                {184'd0, wrptr}, {184'd0, VEC[i][7:0]});
            check_sel(12'h200, "R3 R4 newest entry");
            check_sel(12'h201, "R4 second entry");
            check_sel(12'h20F, "R5 oldest entry");
        end

        // R7: same-cycle read returns pre-write contents
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 4'd11; wr_stack = 1'b0;
        wr_src = 64'hA000; wr_tgt = 64'hB001;
        check_sel(12'h200, "R7 read during write");
        @(negedge clk);
        wr_en = 1'b0;
        model_write(4'd11, 1'b0, 64'hA000, 64'hB001);
        check_sel(12'h200, "R7 read after write");

        // R1: wrap at depth 16
        for (int i = 0; i < 20; i++)
            do_write(4'd4, 1'b0, 64'h2000 + 64'(i) * 4, 64'h3000 + 64'(i) * 4);
        check_ptr("R1 wrap at 16");
        check_sel(12'h200, "R1 newest after wrap");
        check_sel(12'h20F, "R1 oldest after wrap");
        check_sel(12'h210, "R9 beyond depth 16");
        check_sel(12'h1FF, "R9 below base");

        // R1: clamp of depth select
        @(negedge clk);
        depth_sel = 3'd7; bd = 256;
        check_sel(12'h2FF, "R1 last entry at clamped depth");
        check_sel(12'h300, "R1 R9 first entry past clamp");
        for (int i = 0; i < 256; i++)
            do_write(4'd5, 1'b0, 64'h4000 + 64'(i) * 8, 64'h5000 + 64'(i) * 8);
        check_ptr("R1 full lap at 256");
        check_sel(12'h200, "R1 newest at 256");
        check_sel(12'h2FF, "R1 oldest at 256");
        do_write(4'd13, 1'b1, 64'h0, 64'h0);
        check_ptr("R5 pop at 256");
        check_sel(12'h2FF, "R5 popped slot invalid");

        // R8: reset mid-stream
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mptr = 0;
        for (int i = 0; i < 256; i++) mval[i] = 0;
        check_ptr("R8 ptr after second reset");
        check_sel(12'h200, "R8 valid after second reset");

        summary();
        $finish;
    end

endmodule